// File: doc/BRIEF.md
# Device Power State Controller

This block is the power-management state machine on the device side of a bus-attached peripheral function. It holds the function's power state, which is one of D0, D1, D2 or D3hot. It accepts state-change requests through a single-cycle register write. Each request is checked against the transition rules and against the states the function is built to support. A request that breaks a rule is refused and the current state stays as it was. A higher state number means lower power, and the function takes longer to return to D0 from it.

The block keeps a wake-enable bit and a sticky wake-status bit. It drives an active-low wake request, but only from states whose bit is set in the wake-support mask. It also drives two control outputs:
- an access-enable output, which lets the function run only in D0 and only after any recovery time has passed;
- a context-reset output, which clears the function's internal state.

D3cold is represented by a main-power input. When main power drops, the whole block is reset. When power returns, the block starts again in D0 with every field cleared.

Top module: `pm_state_ctrl`

## Requirements
- R1: While `rst_ni` is low, the control/status register reads 0, the state is D0, `access_en_o` is low, `ctx_rst_o` is high, `wake_n_o` is high and `req_err_o` is low. After reset is released, with no write made, `access_en_o` goes high and `ctx_rst_o` goes low.
- R2: The control/status register carries the power state in bits 1:0, coded 00=D0, 01=D1, 10=D2, 11=D3hot. A write with a legal target puts that state into bits 1:0 from the next cycle on. Without a write, the state does not change.
- R3: A write whose target state is numerically lower than the current state, and is not D0, is refused. The state is kept, and `req_err_o` is high for the one cycle after the write. A write whose target equals the current state changes nothing and is not an error.
- R4: A write that targets D1 or D2 is refused, with the same `req_err_o` pulse, when that state is disabled by its parameter. The capability output shows D1 support in bit 9, D2 support in bit 10, the wake-support mask in bits 15:11 (11=D0, 12=D1, 13=D2, 14=D3hot, 15=D3cold) and the value 3 in bits 2:0.
- R5: Writing 1 to bit 8 (wake enable) sets the enable only if the wake-support bit of the state in the same write's bits 1:0 is set. For target 11, either the D3hot bit or the D3cold bit is enough. Otherwise the enable keeps its value and `req_err_o` pulses. Writing 0 to bit 8 always clears the enable.
- R6: Bit 15 (wake status) is set by `wake_evt_i` and stays set until a write with bit 15 equal to 1 clears it. When an event and a clearing write arrive in the same cycle, the event wins.
- R7: `wake_n_o` is low exactly while wake status is set, wake enable is set, and the support bit of the current state is set.
- R8: `access_en_o` is low whenever the state is not D0.
- R9: After a move from D3hot to D0, `access_en_o` stays low for `RECOVERY_CYCLES` cycles after the write edge. A move to D0 from D1 or D2 raises it in the very next cycle.
- R10: With `D3H_KEEP_CTX` = 0, a move from D3hot to D0 drives `ctx_rst_o` high for exactly one cycle, the cycle after the write.
- R11: When `main_pwr_i` falls, every output returns at once to its R1 reset value. When `main_pwr_i` rises again, the block is in D0 with wake enable and wake status cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| main_pwr_i | input | 1 | Main power good; low models D3cold |
| wr_en_i | input | 1 | Write strobe for the control/status register |
| wr_data_i | input | 16 | Write data: state, wake enable, wake-status clear |
| wake_evt_i | input | 1 | Wake event from the function |
| cap_o | output | 16 | Capability register value |
| csr_o | output | 16 | Control/status register value |
| state_o | output | 2 | Current power state |
| access_en_o | output | 1 | Function may operate |
| ctx_rst_o | output | 1 | Context reset for the function |
| wake_n_o | output | 1 | Active-low wake request |
| req_err_o | output | 1 | One-cycle pulse after a refused request |

## Verification
A wrong state register shows up in bits 1:0 of `csr_o` one cycle after the write that caused it. It also shows on `access_en_o` in that same cycle. A wrong wake-enable or wake-status bit shows up within one cycle as a wrong level on `wake_n_o`. A recovery counter that is loaded badly or misses a step moves the rising edge of `access_en_o` away from the cycle computed in the bench.

The stimulus reaches these faults in several ways:
- refused moves in both directions, which check that the state and enable are held;
- a clearing write, followed by a new event, which checks the sticky status;
- a drop of main power in the middle of a sequence, which checks that nothing survives it.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic [1:0] {
    PS_D0  = 2'd0,
    PS_D1  = 2'd1,
    PS_D2  = 2'd2,
    PS_D3H = 2'd3
  } pstate_e;

  localparam int CSR_WEN_BIT   = 8;
  localparam int CSR_WSTS_BIT  = 15;
  localparam int CAP_D1_BIT    = 9;
  localparam int CAP_D2_BIT    = 10;
  localparam int CAP_WMASK_LSB = 11;
  localparam logic [2:0] CAP_VERSION = 3'd3;
endpackage

// File: rtl/pm_trans_check.sv
module pm_trans_check
  import pm_pkg::*;
#(
  parameter bit D1_SUP = 1'b1,
  parameter bit D2_SUP = 1'b1
) (
  input  pstate_e cur_i,
  input  pstate_e req_i,
  input  logic    req_vld_i,
  output logic    accept_o,
  output logic    reject_o,
  output logic    exit_d3h_o
);
  logic [3:0] sup;
  logic deeper, same, to_d0, legal;

  assign sup = {1'b1, 1'(D2_SUP), 1'(D1_SUP), 1'b1};

  always_comb begin
    deeper     = req_i > cur_i;
    same       = req_i == cur_i;
    to_d0      = req_i == PS_D0;
    legal      = to_d0 | same | (deeper & sup[req_i]);
    accept_o   = req_vld_i & legal & ~same;
    reject_o   = req_vld_i & ~legal;
    exit_d3h_o = accept_o & to_d0 & (cur_i == PS_D3H);
  end
endmodule

// File: rtl/pm_wake_ctrl.sv
module pm_wake_ctrl
  import pm_pkg::*;
#(
  parameter logic [4:0] WAKE_MASK = 5'b11001
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    wr_en_i,
  input  logic    wen_bit_i,
  input  logic    wsts_bit_i,
  input  pstate_e req_i,
  input  pstate_e cur_i,
  input  logic    evt_i,
  output logic    en_o,
  output logic    sts_o,
  output logic    fail_o,
  output logic    wake_n_o
);
  logic en_q, sts_q, req_sup, cur_sup;

  always_comb begin
    if (req_i == PS_D3H) req_sup = WAKE_MASK[3] | WAKE_MASK[4];
    else                 req_sup = WAKE_MASK[3'(req_i)];
    cur_sup = WAKE_MASK[3'(cur_i)];
    fail_o  = wr_en_i & wen_bit_i & ~req_sup;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      sts_q <= 1'b0;
    end else begin
      if (wr_en_i) begin
        if (!wen_bit_i)   en_q <= 1'b0;
        else if (req_sup) en_q <= 1'b1;
      end
      // event beats a same-cycle clear
      if (evt_i)                        sts_q <= 1'b1;
      else if (wr_en_i && wsts_bit_i)   sts_q <= 1'b0;
    end
  end

  assign en_o     = en_q;
  assign sts_o    = sts_q;
  assign wake_n_o = ~(en_q & sts_q & cur_sup);

  a_r6_sts_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_q && !(wr_en_i && wsts_bit_i) |=> sts_q);
  a_r6_evt_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> sts_q);
  a_r5_fail_keeps_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |=> $stable(en_q));
endmodule

// File: rtl/pm_recovery.sv
module pm_recovery #(
  parameter int unsigned CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic busy_o
);
  localparam int unsigned CW = $clog2(CYCLES + 2);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = cnt_q != '0;

  a_r9_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(CYCLES));
endmodule

// File: rtl/pm_state_ctrl.sv
module pm_state_ctrl
  import pm_pkg::*;
#(
  parameter bit          D1_SUP          = 1'b1,
  parameter bit          D2_SUP          = 1'b1,
  parameter logic [4:0]  WAKE_MASK       = 5'b11001,
  parameter bit          D3H_KEEP_CTX    = 1'b0,
  parameter int unsigned RECOVERY_CYCLES = 10
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        main_pwr_i,
  input  logic        wr_en_i,
  input  logic [15:0] wr_data_i,
  input  logic        wake_evt_i,
  output logic [15:0] cap_o,
  output logic [15:0] csr_o,
  output logic [1:0]  state_o,
  output logic        access_en_o,
  output logic        ctx_rst_o,
  output logic        wake_n_o,
  output logic        req_err_o
);
  logic    por_n;
  pstate_e state_q, req_state;
  logic    accept, reject, exit_d3h, wake_fail;
  logic    wen, wsts, rec_busy, ctx_q, err_q;

  // losing main power acts as a full power-on reset
  assign por_n     = rst_ni & main_pwr_i;
  assign req_state = pstate_e'(wr_data_i[1:0]);

  pm_trans_check #(.D1_SUP(D1_SUP), .D2_SUP(D2_SUP)) u_trans (
    .cur_i      (state_q),
    .req_i      (req_state),
    .req_vld_i  (wr_en_i),
    .accept_o   (accept),
    .reject_o   (reject),
    .exit_d3h_o (exit_d3h)
  );

  pm_wake_ctrl #(.WAKE_MASK(WAKE_MASK)) u_wake (
    .clk_i      (clk_i),
    .rst_ni     (por_n),
    .wr_en_i    (wr_en_i),
    .wen_bit_i  (wr_data_i[CSR_WEN_BIT]),
    .wsts_bit_i (wr_data_i[CSR_WSTS_BIT]),
    .req_i      (req_state),
    .cur_i      (state_q),
    .evt_i      (wake_evt_i),
    .en_o       (wen),
    .sts_o      (wsts),
    .fail_o     (wake_fail),
    .wake_n_o   (wake_n_o)
  );

  pm_recovery #(.CYCLES(RECOVERY_CYCLES)) u_rec (
    .clk_i  (clk_i),
    .rst_ni (por_n),
    .load_i (exit_d3h),
    .busy_o (rec_busy)
  );

  always_ff @(posedge clk_i or negedge por_n) begin
    if (!por_n) begin
      state_q <= PS_D0;
      ctx_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (accept) state_q <= req_state;
      ctx_q <= exit_d3h & ~D3H_KEEP_CTX;
      err_q <= reject | wake_fail;
    end
  end

  always_comb begin
    cap_o = '0;
    cap_o[2:0] = CAP_VERSION;
    cap_o[CAP_D1_BIT] = D1_SUP;
    cap_o[CAP_D2_BIT] = D2_SUP;
    cap_o[CAP_WMASK_LSB +: 5] = WAKE_MASK;
    csr_o = '0;
    csr_o[1:0] = state_q;
    csr_o[CSR_WEN_BIT]  = wen;
    csr_o[CSR_WSTS_BIT] = wsts;
  end

  assign state_o     = state_q;
  assign access_en_o = por_n & (state_q == PS_D0) & ~rec_busy;
  assign ctx_rst_o   = ctx_q | ~por_n;
  assign req_err_o   = err_q;

  a_r3_never_shallower: assert property (@(posedge clk_i) disable iff (!por_n)
    (state_q != $past(state_q)) |-> (state_q == PS_D0 || state_q > $past(state_q)));
  a_r2_hold_no_write: assert property (@(posedge clk_i) disable iff (!por_n)
    !wr_en_i |=> $stable(state_q));
  a_r8_access_off: assert property (@(posedge clk_i) disable iff (!por_n)
    state_q != PS_D0 |-> !access_en_o);
  a_r10_ctx_one_cycle: assert property (@(posedge clk_i) disable iff (!por_n)
    ctx_q |=> !ctx_q);
endmodule

// File: tb/tb_pm_state_ctrl.sv
`timescale 1ns/1ps
module tb_pm_state_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        main_pwr_i = 1'b1;
  logic        wr_en_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic        wake_evt_i = 1'b0;
  logic [15:0] cap_o, csr_o;
  logic [1:0]  state_o;
  logic        access_en_o, ctx_rst_o, wake_n_o, req_err_o;

  int errors = 0;
  int checks = 0;

  always #2.5 clk_i = ~clk_i;

  pm_state_ctrl #(
    .D1_SUP(1'b1), .D2_SUP(1'b0), .WAKE_MASK(5'b01001),
    .D3H_KEEP_CTX(1'b0), .RECOVERY_CYCLES(3)
  ) dut (.*);

  typedef struct packed {
    logic [15:0] csr;
    logic acc, err, wkn, ctx;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  // monitor: compares queued expectations away from the active edge
  initial forever begin
    @(negedge clk_i);
    while (exp_q.size() > 0) begin
      exp_t  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (csr_o !== e.csr || access_en_o !== e.acc || req_err_o !== e.err ||
          wake_n_o !== e.wkn || ctx_rst_o !== e.ctx) begin
        errors++;
        $display("FAIL %s: csr=%h acc=%b err=%b wake_n=%b ctx=%b exp csr=%h acc=%b err=%b wake_n=%b ctx=%b",
                 t, csr_o, access_en_o, req_err_o, wake_n_o, ctx_rst_o,
                 e.csr, e.acc, e.err, e.wkn, e.ctx);
      end
    end
  end

  task automatic step(input logic wr, input logic [15:0] d, input logic evt,
                      input logic pwr, input string tag, input logic [15:0] ecsr,
                      input logic eacc, input logic eerr, input logic ewkn,
                      input logic ectx);
    exp_t e;
    @(negedge clk_i); #1;
    wr_en_i = wr; wr_data_i = d; wake_evt_i = evt; main_pwr_i = pwr;
    @(posedge clk_i); #1;
    wr_en_i = 1'b0; wake_evt_i = 1'b0;
    e.csr = ecsr; e.acc = eacc; e.err = eerr; e.wkn = ewkn; e.ctx = ectx;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1 reset values
    step(0, 16'h0000, 0, 1, "R1 in reset", 16'h0000, 0, 0, 1, 1);
    @(negedge clk_i); rst_ni = 1'b1;
    step(0, 16'h0000, 0, 1, "R1 after release", 16'h0000, 1, 0, 1, 0);
    // R4 capability layout
    checks++;
    if (cap_o !== 16'h4A03) begin
      errors++;
      $display("FAIL R4 cap: actual=%h expected=%h", cap_o, 16'h4A03);
    end
    step(1, 16'h0002, 0, 1, "R4 unsupported D2", 16'h0000, 1, 1, 1, 0);
    step(1, 16'h0001, 0, 1, "R2 R8 to D1", 16'h0001, 0, 0, 1, 0);
    step(1, 16'h0003, 0, 1, "R2 D1 to D3hot", 16'h0003, 0, 0, 1, 0);
    step(1, 16'h0001, 0, 1, "R3 D3hot to D1 refused", 16'h0003, 0, 1, 1, 0);
    step(1, 16'h0003, 0, 1, "R3 same state no error", 16'h0003, 0, 0, 1, 0);
    step(1, 16'h0103, 0, 1, "R5 enable for D3hot", 16'h0103, 0, 0, 1, 0);
    step(0, 16'h0000, 1, 1, "R6 R7 event in D3hot", 16'h8103, 0, 0, 0, 0);
    step(1, 16'h8103, 0, 1, "R6 write-1 clear", 16'h0103, 0, 0, 1, 0);
    step(1, 16'h8103, 1, 1, "R6 event beats clear", 16'h8103, 0, 0, 0, 0);
    step(1, 16'h8100, 0, 1, "R9 R10 D3hot to D0", 16'h0100, 0, 0, 1, 1);
    step(0, 16'h0000, 0, 1, "R9 R10 recovery 2", 16'h0100, 0, 0, 1, 0);
    step(0, 16'h0000, 0, 1, "R9 recovery 1", 16'h0100, 0, 0, 1, 0);
    step(0, 16'h0000, 0, 1, "R9 recovery done", 16'h0100, 1, 0, 1, 0);
    step(1, 16'h0000, 0, 1, "R5 disable always works", 16'h0000, 1, 0, 1, 0);
    step(1, 16'h0101, 0, 1, "R5 enable for D1 refused", 16'h0001, 0, 1, 1, 0);
    step(0, 16'h0000, 1, 1, "R7 status without enable", 16'h8001, 0, 0, 1, 0);
    step(1, 16'h8000, 0, 1, "R9 D1 to D0 no wait", 16'h0000, 1, 0, 1, 0);
    step(1, 16'h0100, 0, 1, "R5 enable for D0", 16'h0100, 1, 0, 1, 0);
    step(0, 16'h0000, 1, 1, "R7 wake from D0", 16'h8100, 1, 0, 0, 0);
    step(1, 16'h0103, 0, 1, "R2 to D3hot before power loss", 16'h8103, 0, 0, 0, 0);
    step(0, 16'h0000, 0, 0, "R11 main power lost", 16'h0000, 0, 0, 1, 1);
    step(1, 16'h0001, 0, 0, "R11 write while unpowered", 16'h0000, 0, 0, 1, 1);
    step(0, 16'h0000, 0, 1, "R11 power restored in D0", 16'h0000, 1, 0, 1, 0);
    repeat (3) @(negedge clk_i);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule